// File: doc/BRIEF.md
# MSI Capability Register File

This block holds the configuration-space registers of a message signalled interrupt capability for a single function. Software reaches it through a byte-enabled dword port whose offset is relative to the capability base. A message dispatcher next to it reads the enable, the granted vector count, the message address and data, the per-vector mask and the pending bits from dedicated outputs. The dispatcher reports masked events and completed deliveries through set and clear strobes for the pending register.

Three build-time parameters shape the register file: the log2 of the supported vector count (0 to 5), 64-bit message addressing, and per-vector masking. The last two move the data, mask and pending registers and change which bits accept writes. The capability spans 0x0A, 0x0E, 0x14 or 0x18 bytes for the four combinations of (addressing, masking): (32-bit, none), (64-bit, none), (32-bit, mask), (64-bit, mask). The enable bit is the state of a two-state controller, DISABLED and ENABLED. The transition ARM (a control write with the enable bit set) moves DISABLED to ENABLED. The transition DISARM (a control write with it clear) moves ENABLED back to DISABLED. In ENABLED the legacy level interrupt request is held off.

Top module: `msi_cap_regs`

## Requirements
- R1: After reset the enable bit, the granted-count field, both address registers, the data register, the mask register and the pending register all read zero.
- R2: Dword 0 reads enable at bit 16, the supported log2 count at bits 19:17, the granted log2 count at bits 22:20, the 64-bit flag at bit 23 and the mask flag at bit 24; all other bits read zero. Only the enable and granted fields take writes, through byte lane 2. A write with bit 16 set enters ENABLED, and one with it clear returns to DISABLED.
- R3: A granted-count write larger than the supported log2 count is stored as the supported count. Smaller or equal values are stored unchanged.
- R4: The low address register at dword 1 always reads zero in bits 1:0. Bits 31:2 are writable.
- R5: With 64-bit addressing, dword 2 is a fully writable high address register and the 16-bit data register sits in bits 15:0 of dword 3. Without it, the data register is in dword 2. Data bits 31:16 read zero, and the address output is {high, low}.
- R6: The mask register (dword 4 with 64-bit addressing, dword 3 without) keeps only bits 0 to N-1 writable, where N is the supported vector count. Higher bits read zero.
- R7: The pending register (dword 5 with 64-bit addressing, dword 4 without) reads live state and ignores configuration writes. A pend_set_i bit sets it, and a pend_clr_i bit clears it. Set wins over clear in the same cycle.
- R8: Pending bits at or above 2^granted are forced to zero. This uses the granted value that is being stored in the same cycle, so a set for such a vector is dropped and lowering the granted count discards higher pending bits.
- R9: Only byte lanes whose enable is set change. Writes to dwords outside the capability (dwords 6 and 7 in the largest layout) change nothing, and those dwords read zero.
- R10: intx_req_o follows intx_req_i while DISABLED and is held at zero while ENABLED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_dw | input | 3 | Dword offset from capability base |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw (combinational) |
| pend_set_i | input | 32 | Per-vector pending set strobes |
| pend_clr_i | input | 32 | Per-vector pending clear strobes |
| intx_req_i | input | 1 | Legacy interrupt request from the function |
| intx_req_o | output | 1 | Gated legacy interrupt request |
| msi_enable_o | output | 1 | Enable bit |
| msi_mme_o | output | 3 | Granted log2 vector count |
| msi_addr_o | output | 64 | Message address |
| msi_data_o | output | 16 | Message data |
| msi_mask_o | output | 32 | Per-vector mask |
| msi_pending_o | output | 32 | Per-vector pending bits |

## Verification
A control write that lowers the granted count can arrive in the same cycle as a dispatcher set strobe for a vector that the new count excludes. The bench drives both in one clock edge and expects that vector's pending bit to stay clear. It also expects bits already pending above the new limit to disappear. The bench also writes all ones to the pending dword in the same cycle as a set strobe. It expects the set bit to appear and the written value to leave no trace.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int MAX_VEC = 32;
    localparam int DW_W    = 3;

    typedef enum logic [0:0] {
        ST_DISABLED = 1'b0,
        ST_ENABLED  = 1'b1
    } msi_state_e;

    // Merge a byte-enabled write into an old value under a write mask.
    function automatic logic [31:0] byte_merge(
        input logic [31:0] old_v,
        input logic [31:0] new_v,
        input logic [3:0]  be,
        input logic [31:0] wmask
    );
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                r[i*8 +: 8] = (old_v[i*8 +: 8] & ~wmask[i*8 +: 8])
                            | (new_v[i*8 +: 8] &  wmask[i*8 +: 8]);
            end
        end
        return r;
    endfunction

    // Mask of vectors covered by a granted log2 count.
    function automatic logic [31:0] alloc_mask(input logic [2:0] lg);
        logic [5:0] n;
        n = 6'd1 << lg;
        return 32'((64'h1 << n) - 64'h1);
    endfunction

endpackage

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       wr_en_bit,
    input  logic [2:0] wr_mme,
    input  logic       intx_req_i,
    output logic       msi_enable_o,
    output logic [2:0] mme_q_o,
    output logic [2:0] mme_nxt_o,
    output logic       intx_req_o
);

    localparam logic [2:0] CAP_LG = 3'(VEC_LOG2);

    msi_state_e st_q, st_d;
    logic [2:0] mme_q, mme_d;

    // Next-state: ARM and DISARM transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DISABLED: if (ctl_wr && wr_en_bit)  st_d = ST_ENABLED;
            ST_ENABLED:  if (ctl_wr && !wr_en_bit) st_d = ST_DISABLED;
            default:     st_d = ST_DISABLED;
        endcase
    end

    // Granted-count clamp
    always_comb begin
        mme_d = mme_q;
        if (ctl_wr) begin
            mme_d = (wr_mme > CAP_LG) ? CAP_LG : wr_mme;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_DISABLED;
            mme_q <= 3'd0;
        end else begin
            st_q  <= st_d;
            mme_q <= mme_d;
        end
    end

    // Outputs per state
    always_comb begin
        msi_enable_o = 1'b0;
        intx_req_o   = 1'b0;
        unique case (st_q)
            ST_DISABLED: begin
                msi_enable_o = 1'b0;
                intx_req_o   = intx_req_i;
            end
            ST_ENABLED: begin
                msi_enable_o = 1'b1;
                intx_req_o   = 1'b0;
            end
            default: begin
                msi_enable_o = 1'b0;
                intx_req_o   = 1'b0;
            end
        endcase
    end

    assign mme_q_o   = mme_q;
    assign mme_nxt_o = mme_d;

    p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (msi_enable_o == $past(wr_en_bit)));

    p_mme_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (mme_q_o == (($past(wr_mme) > CAP_LG) ? CAP_LG : $past(wr_mme))));

    p_mme_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(mme_q_o));

    p_intx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msi_enable_o |-> !intx_req_o);

endmodule

// File: rtl/msi_msg_regs.sv
module msi_msg_regs
    import msi_cap_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [DW_W-1:0] dw,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    output logic [31:0]     addr_lo_o,
    output logic [31:0]     addr_hi_o,
    output logic [15:0]     data_o
);

    localparam logic [DW_W-1:0] LO_DW   = 3'd1;
    localparam logic [DW_W-1:0] HI_DW   = 3'd2;
    localparam logic [DW_W-1:0] DATA_DW = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [31:0]     LO_WM   = 32'hFFFF_FFFC;

    logic [31:0] lo_q;
    logic [31:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            data_q <= '0;
        end else if (wr) begin
            if (dw == LO_DW)   lo_q   <= byte_merge(lo_q, wdata, be, LO_WM);
            if (dw == DATA_DW) data_q <= byte_merge(data_q, wdata, be, 32'h0000_FFFF);
        end
    end

    generate
        if (ADDR64) begin : g_hi
            logic [31:0] hi_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  hi_q <= '0;
                else if (wr && dw == HI_DW)  hi_q <= byte_merge(hi_q, wdata, be, 32'hFFFF_FFFF);
            end
            assign addr_hi_o = hi_q;
        end else begin : g_no_hi
            assign addr_hi_o = '0;
        end
    endgenerate

    assign addr_lo_o = lo_q;
    assign data_o    = data_q[15:0];

    p_lo_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && dw == LO_DW) |=> (addr_lo_o[1:0] == 2'b00));

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(data_o) && $stable(addr_lo_o)));

endmodule

// File: rtl/msi_mask_pend.sv
module msi_mask_pend
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 2,
    parameter bit ADDR64   = 1'b1,
    parameter bit MASK_EN  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [DW_W-1:0] dw,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    input  logic [2:0]      mme_nxt,
    input  logic [31:0]     pend_set,
    input  logic [31:0]     pend_clr,
    output logic [31:0]     mask_o,
    output logic [31:0]     pend_o
);

    localparam int              NVEC    = 1 << VEC_LOG2;
    localparam logic [31:0]     MASK_WM = 32'((64'h1 << NVEC) - 64'h1);
    localparam logic [DW_W-1:0] MASK_DW = ADDR64 ? 3'd4 : 3'd3;

    generate
        if (MASK_EN) begin : g_mask
            logic [31:0] mask_q, pend_q, pend_d;

            always_comb begin
                pend_d = ((pend_q & ~pend_clr) | pend_set) & alloc_mask(mme_nxt);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q <= '0;
                    pend_q <= '0;
                end else begin
                    pend_q <= pend_d;
                    if (wr && dw == MASK_DW) mask_q <= byte_merge(mask_q, wdata, be, MASK_WM);
                end
            end

            assign mask_o = mask_q;
            assign pend_o = pend_q;
        end else begin : g_no_mask
            assign mask_o = '0;
            assign pend_o = '0;
        end
    endgenerate

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask_o));

    p_no_spont_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set == 32'h0) |=> ((pend_o & ~$past(pend_o)) == 32'h0));

    p_clr_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_clr & ~pend_set) != 32'h0) |=> ((pend_o & $past(pend_clr & ~pend_set)) == 32'h0));

endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int VEC_LOG2 = 2,
    parameter bit ADDR64   = 1'b1,
    parameter bit MASK_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [2:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] pend_set_i,
    input  logic [31:0] pend_clr_i,
    input  logic        intx_req_i,
    output logic        intx_req_o,
    output logic        msi_enable_o,
    output logic [2:0]  msi_mme_o,
    output logic [63:0] msi_addr_o,
    output logic [15:0] msi_data_o,
    output logic [31:0] msi_mask_o,
    output logic [31:0] msi_pending_o
);

    localparam logic [2:0] CAP_LG = 3'(VEC_LOG2);

    logic        ctl_wr;
    logic [2:0]  mme_nxt;
    logic [31:0] addr_lo, addr_hi;
    logic [31:0] ctl_word;

    assign ctl_wr = cfg_wr_en && (cfg_dw == 3'd0) && cfg_be[2];

    msi_ctrl_fsm #(.VEC_LOG2(VEC_LOG2)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .wr_en_bit    (cfg_wdata[16]),
        .wr_mme       (cfg_wdata[22:20]),
        .intx_req_i   (intx_req_i),
        .msi_enable_o (msi_enable_o),
        .mme_q_o      (msi_mme_o),
        .mme_nxt_o    (mme_nxt),
        .intx_req_o   (intx_req_o)
    );

    msi_msg_regs #(.ADDR64(ADDR64)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr_en),
        .dw        (cfg_dw),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .addr_lo_o (addr_lo),
        .addr_hi_o (addr_hi),
        .data_o    (msi_data_o)
    );

    msi_mask_pend #(.VEC_LOG2(VEC_LOG2), .ADDR64(ADDR64), .MASK_EN(MASK_EN)) u_mp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr_en),
        .dw       (cfg_dw),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .mme_nxt  (mme_nxt),
        .pend_set (pend_set_i),
        .pend_clr (pend_clr_i),
        .mask_o   (msi_mask_o),
        .pend_o   (msi_pending_o)
    );

    assign msi_addr_o = {addr_hi, addr_lo};
    assign ctl_word   = {7'd0, MASK_EN, ADDR64, msi_mme_o, CAP_LG, msi_enable_o, 16'h0000};

    // Read mux; layout depends on the two options
    always_comb begin
        cfg_rdata = 32'h0;
        unique case (cfg_dw)
            3'd0: cfg_rdata = ctl_word;
            3'd1: cfg_rdata = addr_lo;
            3'd2: cfg_rdata = ADDR64 ? addr_hi : {16'h0, msi_data_o};
            3'd3: cfg_rdata = ADDR64 ? {16'h0, msi_data_o} : msi_mask_o;
            3'd4: cfg_rdata = ADDR64 ? msi_mask_o : msi_pending_o;
            3'd5: cfg_rdata = ADDR64 ? msi_pending_o : 32'h0;
            default: cfg_rdata = 32'h0;
        endcase
    end

    p_mme_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msi_mme_o <= CAP_LG);

    p_pend_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_pending_o & ~alloc_mask(msi_mme_o)) == 32'h0);

endmodule

// File: tb/msi_cap_regs_tb.sv
module msi_cap_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] pend_set_i = '0;
    logic [31:0] pend_clr_i = '0;
    logic        intx_req_i = 1'b0;
    logic        intx_req_o, msi_enable_o;
    logic [2:0]  msi_mme_o;
    logic [63:0] msi_addr_o;
    logic [15:0] msi_data_o;
    logic [31:0] msi_mask_o, msi_pending_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Config under test: 4 vectors, 64-bit addressing, masking
    localparam int CAPL = 2;
    localparam logic [31:0] CTL_RO = (32'(CAPL) << 17) | (32'h1 << 23) | (32'h1 << 24);

    always #2 clk = ~clk;

    msi_cap_regs #(.VEC_LOG2(CAPL), .ADDR64(1'b1), .MASK_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pend_set_i(pend_set_i), .pend_clr_i(pend_clr_i),
        .intx_req_i(intx_req_i), .intx_req_o(intx_req_o),
        .msi_enable_o(msi_enable_o), .msi_mme_o(msi_mme_o),
        .msi_addr_o(msi_addr_o), .msi_data_o(msi_data_o),
        .msi_mask_o(msi_mask_o), .msi_pending_o(msi_pending_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write with optional pending strobes in the same cycle
    task automatic wr_ps(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d,
                         input logic [31:0] ps, input logic [31:0] pc, input bit do_wr);
        @(negedge clk);
        cfg_wr_en = do_wr; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        pend_set_i = ps; pend_clr_i = pc;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0; pend_set_i = '0; pend_clr_i = '0;
    endtask

    task automatic wr(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d);
        wr_ps(dw, be, d, 32'h0, 32'h0, 1'b1);
    endtask

    task automatic rd(input logic [2:0] dw, output logic [31:0] v);
        cfg_dw = dw;
        #1 v = cfg_rdata;
    endtask

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset contents
        for (int d = 0; d < 8; d++) begin
            rd(3'(d), v);
            chk(d == 0 ? "R1 R2 ctl reset" : "R1 reset dword", {32'h0, v}, {32'h0, d == 0 ? CTL_RO : 32'h0});
        end
        chk("R1 enable port", {63'h0, msi_enable_o}, 64'h0);

        // R2 / R3: all-ones control write clamps granted count
        wr(3'd0, 4'hF, 32'hFFFF_FFFF);
        rd(3'd0, v);
        chk("R2 R3 ctl all ones", {32'h0, v}, {32'h0, CTL_RO | 32'h1_0000 | (32'(CAPL) << 20)});
        chk("R2 enable port", {63'h0, msi_enable_o}, 64'h1);

        // R3: sweep every request
        for (int m = 0; m < 8; m++) begin
            int e;
            e = (m > CAPL) ? CAPL : m;
            wr(3'd0, 4'h4, 32'h1_0000 | (32'(m) << 20));
            chk("R3 granted clamp", {61'h0, msi_mme_o}, 64'(e));
        end

        // R2: lane 2 disabled leaves control alone
        wr(3'd0, 4'hB, 32'h0);
        chk("R2 lane gating", {63'h0, msi_enable_o}, 64'h1);

        // R10: INTx gating in both states
        intx_req_i = 1'b1;
        #1 chk("R10 enabled quiet", {63'h0, intx_req_o}, 64'h0);
        wr(3'd0, 4'h4, 32'h0);
        chk("R10 disabled passes", {63'h0, intx_req_o}, 64'h1);
        chk("R2 disarm", {63'h0, msi_enable_o}, 64'h0);
        intx_req_i = 1'b0;
        #1 chk("R10 follows low", {63'h0, intx_req_o}, 64'h0);

        // R4 / R9: sweep byte enables on the low address
        for (int b = 0; b < 16; b++) begin
            wr(3'd1, 4'hF, 32'h0);
            wr(3'd1, 4'(b), 32'hFFFF_FFFF);
            rd(3'd1, v);
            chk("R4 R9 addr lo lanes", {32'h0, v}, {32'h0, be_mask(4'(b)) & 32'hFFFF_FFFC});
        end

        // R5: high address and data placement
        wr(3'd1, 4'hF, 32'h1234_5677);
        wr(3'd2, 4'hF, 32'hDEAD_BEEF);
        wr(3'd3, 4'hF, 32'hFFFF_A5C3);
        rd(3'd2, v);
        chk("R5 addr hi", {32'h0, v}, 64'hDEAD_BEEF);
        rd(3'd3, v);
        chk("R5 data upper zero", {32'h0, v}, 64'h0000_A5C3);
        chk("R5 addr port", msi_addr_o, 64'hDEAD_BEEF_1234_5674);
        chk("R5 data port", {48'h0, msi_data_o}, 64'hA5C3);

        // R6: mask writable only below N
        wr(3'd4, 4'hF, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R6 mask width", {32'h0, v}, 64'h0000_000F);
        wr(3'd4, 4'hE, 32'h0);
        chk("R6 lane 0 only", {32'h0, msi_mask_o}, 64'h0000_000F);
        wr(3'd4, 4'h1, 32'h0000_0005);
        chk("R6 lane 0 write", {32'h0, msi_mask_o}, 64'h0000_0005);

        // R7: pending set / clear and cfg writes ignored
        wr(3'd0, 4'h4, 32'(CAPL) << 20);
        wr_ps(3'd0, 4'h0, 32'h0, 32'h0000_000A, 32'h0, 1'b0);
        rd(3'd5, v);
        chk("R7 pending set", {32'h0, v}, 64'hA);
        wr_ps(3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 1'b1);
        rd(3'd5, v);
        chk("R7 cfg write ignored, set lands", {32'h0, v}, 64'hB);
        wr_ps(3'd0, 4'h0, 32'h0, 32'h0000_0004, 32'h0000_0006, 1'b0);
        chk("R7 clr with set wins", {32'h0, msi_pending_o}, 64'hD);
        wr_ps(3'd0, 4'h0, 32'h0, 32'h0, 32'h0000_0001, 1'b0);
        chk("R7 clear", {32'h0, msi_pending_o}, 64'hC);

        // R8: shrink granted count while setting an excluded vector
        wr_ps(3'd0, 4'h4, 32'h1 << 20, 32'h0000_0003, 32'h0, 1'b1);
        chk("R8 shrink drops high", {32'h0, msi_pending_o}, 64'h3);
        wr_ps(3'd0, 4'h0, 32'h0, 32'h0000_000C, 32'h0, 1'b0);
        chk("R8 set above limit dropped", {32'h0, msi_pending_o}, 64'h3);
        wr(3'd0, 4'h4, 32'h0);
        chk("R8 single vector", {32'h0, msi_pending_o}, 64'h1);

        // R9: writes beyond capability
        wr(3'd6, 4'hF, 32'hFFFF_FFFF);
        wr(3'd7, 4'hF, 32'hFFFF_FFFF);
        rd(3'd6, v);
        chk("R9 dword6 zero", {32'h0, v}, 64'h0);
        rd(3'd7, v);
        chk("R9 dword7 zero", {32'h0, v}, 64'h0);
        chk("R9 mask intact", {32'h0, msi_mask_o}, 64'h5);
        chk("R9 data intact", {48'h0, msi_data_o}, 64'hA5C3);
        chk("R9 addr intact", msi_addr_o, 64'hDEAD_BEEF_1234_5674);

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int d = 1; d < 6; d++) begin
            rd(3'(d), v);
            chk("R1 re-reset", {32'h0, v}, 64'h0);
        end
        rd(3'd0, v);
        chk("R1 ctl re-reset", {32'h0, v}, {32'h0, CTL_RO});

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule